// File: doc/BRIEF.md
# Programmable Sum-of-Products Output Cell

This block is one configurable logic cell of an erasable programmable logic device. An input vector feeds a small AND plane. Each product term is the AND of the true or complemented input literals that its connection mask selects. The enabled terms are ORed into one sum. A polarity bit can invert that sum. The result then either leaves the cell directly or passes through a storage element first.

The storage element behaves as a D or a T flip-flop. It captures on the rising or the falling edge of its clock. That clock is either the global clock or a clock that one auxiliary product term computes from the inputs. In global-clock mode the same auxiliary term drives the output enable instead. A second dedicated term, when enabled, clears the flop asynchronously. Two select bits decide independently whether the pin output and the feedback output take the registered value or the combinational value. All configuration arrives as static inputs, which are changed only while reset is held.

Top module: `mc_macrocell`

## Requirements
- R1: Each product term p is the AND of the selected literals. Bit 2*i of its mask (`cfg_and_mask[p*2*N_IN + 2*i]`) selects input i true, and bit 2*i+1 selects input i complemented. A term with an empty mask evaluates to 1.
- R2: The combinational sum is the OR of the terms whose `cfg_pt_en` bit is 1. A term whose enable bit is 0 contributes 0, even when its mask is empty.
- R3: When `cfg_invert` is 1, the sum is complemented before it reaches both the flop data input and the combinational outputs.
- R4: When `cfg_async` is 0, the flop is clocked by `clk`, and `pad_oe` equals the auxiliary term (built from `cfg_aux_mask` with the R1 encoding).
- R5: When `cfg_async` is 1, the flop is clocked by the auxiliary term instead of `clk`, and `pad_oe` is held at 1.
- R6: When `cfg_negedge` is 1, the flop captures on the falling edge of the selected clock. Otherwise it captures on the rising edge.
- R7: When `cfg_toggle` is 1, the flop inverts its state on an active edge where its data is 1 and holds where its data is 0. When `cfg_toggle` is 0, it loads its data.
- R8: When `cfg_clr_en` is 1 and the clear term (built from `cfg_clr_mask`) is 1, the flop is forced to 0 at once, whatever its clock does. When `cfg_clr_en` is 0, the clear term has no effect.
- R9: `pad_out` is the flop value when `cfg_out_reg` is 1, and the combinational value when it is 0.
- R10: `fb_out` is the flop value when `cfg_fb_reg` is 1, and the combinational value when it is 0.
- R11: While `rst` is 1 the flop holds 0, so every registered output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock |
| rst | input | 1 | Active-high reset, clears the flop |
| pin | input | N_IN | Array input vector |
| cfg_and_mask | input | NUM_PT*2*N_IN | Connection masks of the sum terms |
| cfg_pt_en | input | NUM_PT | Per-term enable |
| cfg_aux_mask | input | 2*N_IN | Mask of the output-enable / local-clock term |
| cfg_clr_mask | input | 2*N_IN | Mask of the clear term |
| cfg_clr_en | input | 1 | Enables the clear term |
| cfg_invert | input | 1 | Output polarity |
| cfg_async | input | 1 | 1: local term clock, 0: global clock |
| cfg_negedge | input | 1 | Falling-edge capture |
| cfg_toggle | input | 1 | T-flop mode |
| cfg_out_reg | input | 1 | Pin output takes the registered value |
| cfg_fb_reg | input | 1 | Feedback takes the registered value |
| pad_out | output | 1 | Pin data |
| pad_oe | output | 1 | Pin output enable |
| fb_out | output | 1 | Feedback to the array |

## Verification
On every global clock edge the assertions check four things. They check the output-enable source in both clock modes, and that an active clear zeroes the flop. They check rising-edge D loading and T toggling under the global clock, and that the pin and feedback agree whenever their select bits match. Several behaviours fall outside those edges: capture on a locally generated clock, capture on a falling edge, and a clear that asserts between edges. Only the bench scenarios show these. There a reference model is re-evaluated at every input change and every clock edge, and it is compared twice per cycle.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic {
        CLK_GLOBAL = 1'b0,
        CLK_LOCAL  = 1'b1
    } mc_clk_src_e;

    typedef struct packed {
        logic        invert;
        mc_clk_src_e clk_src;
        logic        neg_edge;
        logic        toggle;
        logic        out_reg;
        logic        fb_reg;
        logic        clr_en;
    } mc_mode_t;

    // One literal pair: passes unless a selected polarity disagrees with x.
    function automatic logic lit_pass(input logic use_true, input logic use_comp, input logic x);
        return (~use_true | x) & (~use_comp | ~x);
    endfunction

endpackage

// File: rtl/mc_pterm.sv
module mc_pterm
    import mc_pkg::*;
#(
    parameter int unsigned N_IN = 8,
    localparam int unsigned MW  = 2 * N_IN
) (
    input  logic [N_IN-1:0] x,
    input  logic [MW-1:0]   mask,
    output logic            term
);
    logic [N_IN-1:0] pass;

    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign pass[i] = lit_pass(mask[2*i], mask[2*i+1], x[i]);
    end

    assign term = &pass;
endmodule

// File: rtl/mc_array.sv
module mc_array #(
    parameter int unsigned N_IN   = 8,
    parameter int unsigned NUM_PT = 8,
    localparam int unsigned MW    = 2 * N_IN
) (
    input  logic [N_IN-1:0]      x,
    input  logic [NUM_PT*MW-1:0] and_mask,
    input  logic [NUM_PT-1:0]    pt_en,
    input  logic [MW-1:0]        aux_mask,
    input  logic [MW-1:0]        clr_mask,
    output logic                 sum,
    output logic                 aux_term,
    output logic                 clr_term
);
    logic [NUM_PT-1:0] raw;

    for (genvar p = 0; p < NUM_PT; p++) begin : g_pt
        mc_pterm #(.N_IN(N_IN)) u_pt (
            .x    (x),
            .mask (and_mask[p*MW +: MW]),
            .term (raw[p])
        );
    end

    mc_pterm #(.N_IN(N_IN)) u_aux (
        .x    (x),
        .mask (aux_mask),
        .term (aux_term)
    );

    mc_pterm #(.N_IN(N_IN)) u_clr (
        .x    (x),
        .mask (clr_mask),
        .term (clr_term)
    );

    assign sum = |(raw & pt_en);
endmodule

// File: rtl/mc_store.sv
module mc_store
    import mc_pkg::*;
(
    input  logic        gclk,
    input  logic        lclk,
    input  mc_clk_src_e src,
    input  logic        neg_edge,
    input  logic        toggle,
    input  logic        d,
    input  logic        clr,
    output logic        q
);
    logic clk_sel;
    logic clk_eff;

    assign clk_sel = (src == CLK_LOCAL) ? lclk : gclk;
    assign clk_eff = clk_sel ^ neg_edge;

    always_ff @(posedge clk_eff or posedge clr) begin
        if (clr) begin
            q <= 1'b0;
        end else if (toggle) begin
            q <= q ^ d;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell
    import mc_pkg::*;
#(
    parameter int unsigned N_IN   = 8,
    parameter int unsigned NUM_PT = 8,
    localparam int unsigned MW    = 2 * N_IN
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_IN-1:0]      pin,
    input  logic [NUM_PT*MW-1:0] cfg_and_mask,
    input  logic [NUM_PT-1:0]    cfg_pt_en,
    input  logic [MW-1:0]        cfg_aux_mask,
    input  logic [MW-1:0]        cfg_clr_mask,
    input  logic                 cfg_clr_en,
    input  logic                 cfg_invert,
    input  logic                 cfg_async,
    input  logic                 cfg_negedge,
    input  logic                 cfg_toggle,
    input  logic                 cfg_out_reg,
    input  logic                 cfg_fb_reg,
    output logic                 pad_out,
    output logic                 pad_oe,
    output logic                 fb_out
);
    mc_mode_t mode;
    logic     sum;
    logic     aux_term;
    logic     clr_term;
    logic     d_w;
    logic     q_w;
    logic     clr_any;

    always_comb begin
        mode.invert   = cfg_invert;
        mode.clk_src  = cfg_async ? CLK_LOCAL : CLK_GLOBAL;
        mode.neg_edge = cfg_negedge;
        mode.toggle   = cfg_toggle;
        mode.out_reg  = cfg_out_reg;
        mode.fb_reg   = cfg_fb_reg;
        mode.clr_en   = cfg_clr_en;
    end

    mc_array #(.N_IN(N_IN), .NUM_PT(NUM_PT)) u_array (
        .x        (pin),
        .and_mask (cfg_and_mask),
        .pt_en    (cfg_pt_en),
        .aux_mask (cfg_aux_mask),
        .clr_mask (cfg_clr_mask),
        .sum      (sum),
        .aux_term (aux_term),
        .clr_term (clr_term)
    );

    assign d_w     = sum ^ mode.invert;
    assign clr_any = rst | (mode.clr_en & clr_term);

    mc_store u_store (
        .gclk     (clk),
        .lclk     (aux_term),
        .src      (mode.clk_src),
        .neg_edge (mode.neg_edge),
        .toggle   (mode.toggle),
        .d        (d_w),
        .clr      (clr_any),
        .q        (q_w)
    );

    assign pad_oe  = (mode.clk_src == CLK_LOCAL) ? 1'b1 : aux_term;
    assign pad_out = mode.out_reg ? q_w : d_w;
    assign fb_out  = mode.fb_reg  ? q_w : d_w;
endmodule

// File: rtl/mc_checker.sv
module mc_checker (
    input logic clk,
    input logic rst,
    input logic cfg_async,
    input logic cfg_negedge,
    input logic cfg_toggle,
    input logic cfg_out_reg,
    input logic cfg_fb_reg,
    input logic aux_term,
    input logic clr_any,
    input logic d,
    input logic q,
    input logic pad_out,
    input logic pad_oe,
    input logic fb_out
);
    AST_OE_FROM_TERM: assert property (@(posedge clk) disable iff (rst)
        !cfg_async |-> (pad_oe == aux_term)); // R4

    AST_OE_FORCED: assert property (@(posedge clk) disable iff (rst)
        cfg_async |-> pad_oe); // R5

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr_any |-> !q); // R8

    AST_D_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!cfg_async && !cfg_negedge && !cfg_toggle && !clr_any) |=> (clr_any || (q == $past(d)))); // R7

    AST_T_FLIP: assert property (@(posedge clk) disable iff (rst)
        (!cfg_async && !cfg_negedge && cfg_toggle && !clr_any) |=> (clr_any || (q == ($past(q) ^ $past(d))))); // R7

    AST_SEL_MATCH: assert property (@(posedge clk) disable iff (rst)
        (cfg_out_reg == cfg_fb_reg) |-> (pad_out == fb_out)); // R9

    AST_FB_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (cfg_fb_reg && clr_any) |-> !fb_out); // R10
endmodule

bind mc_macrocell mc_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_async   (cfg_async),
    .cfg_negedge (cfg_negedge),
    .cfg_toggle  (cfg_toggle),
    .cfg_out_reg (cfg_out_reg),
    .cfg_fb_reg  (cfg_fb_reg),
    .aux_term    (aux_term),
    .clr_any     (clr_any),
    .d           (d_w),
    .q           (q_w),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .fb_out      (fb_out)
);

// File: tb/mc_macrocell_tb.sv
module mc_macrocell_tb;
    localparam int N  = 8;
    localparam int NP = 8;
    localparam int MW = 2 * N;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N-1:0]      pin = '0;
    logic [NP*MW-1:0]  cfg_and_mask = '0;
    logic [NP-1:0]     cfg_pt_en = '0;
    logic [MW-1:0]     cfg_aux_mask = '0;
    logic [MW-1:0]     cfg_clr_mask = '0;
    logic cfg_clr_en = 0, cfg_invert = 0, cfg_async = 0, cfg_negedge = 0;
    logic cfg_toggle = 0, cfg_out_reg = 1, cfg_fb_reg = 0;
    logic pad_out, pad_oe, fb_out;

    int checks = 0;
    int errors = 0;
    bit rq = 0;
    bit prev_eff = 0;
    bit e_out, e_oe, e_fb;

    always #5 clk = ~clk;

    mc_macrocell #(.N_IN(N), .NUM_PT(NP)) u_dut (
        .clk(clk), .rst(rst), .pin(pin),
        .cfg_and_mask(cfg_and_mask), .cfg_pt_en(cfg_pt_en),
        .cfg_aux_mask(cfg_aux_mask), .cfg_clr_mask(cfg_clr_mask),
        .cfg_clr_en(cfg_clr_en), .cfg_invert(cfg_invert), .cfg_async(cfg_async),
        .cfg_negedge(cfg_negedge), .cfg_toggle(cfg_toggle),
        .cfg_out_reg(cfg_out_reg), .cfg_fb_reg(cfg_fb_reg),
        .pad_out(pad_out), .pad_oe(pad_oe), .fb_out(fb_out)
    );

    function automatic bit term_of(input logic [MW-1:0] m, input logic [N-1:0] x);
        bit r = 1;
        for (int i = 0; i < N; i++) begin
            if (m[2*i] && !x[i]) r = 0;
            if (m[2*i+1] && x[i]) r = 0;
        end
        return r;
    endfunction

    // Behavioural reference, re-evaluated after every change of inputs or clock.
    task automatic model_eval();
        bit s = 0;
        bit dd, aux, clr, eff;
        for (int p = 0; p < NP; p++)
            if (cfg_pt_en[p] && term_of(cfg_and_mask[p*MW +: MW], pin)) s = 1;
        dd  = s ^ cfg_invert;
        aux = term_of(cfg_aux_mask, pin);
        clr = rst || (cfg_clr_en && term_of(cfg_clr_mask, pin));
        eff = (cfg_async ? aux : clk) ^ cfg_negedge;
        if (clr) rq = 0;
        else if (!prev_eff && eff) rq = cfg_toggle ? (rq ^ dd) : dd;
        prev_eff = eff;
        e_out = cfg_out_reg ? rq : dd;
        e_fb  = cfg_fb_reg ? rq : dd;
        e_oe  = cfg_async ? 1'b1 : aux;
    endtask

    task automatic compare(input string tag);
        checks++;
        if (pad_out !== e_out || pad_oe !== e_oe || fb_out !== e_fb) begin
            errors++;
            $display("FAIL %s t=%0t out/oe/fb actual %b%b%b expected %b%b%b",
                     tag, $time, pad_out, pad_oe, fb_out, e_out, e_oe, e_fb);
        end
    endtask

    task automatic run_cycle(input logic [N-1:0] data, input bit lbit, input bit rv, input string tag);
        @(posedge clk); model_eval();
        #1; pin[N-2:0] = data[N-2:0]; rst = rv; model_eval();
        #1; pin[N-1] = lbit; model_eval();
        #1; compare(tag);
        @(negedge clk); model_eval();
        #2; compare(tag);
    endtask

    task automatic set_mode(input bit inv, input bit asy, input bit neg, input bit tog,
                            input bit outr, input bit fbr, input bit clre);
        run_cycle('0, 1'b0, 1'b1, "R11");
        cfg_invert = inv; cfg_async = asy; cfg_negedge = neg; cfg_toggle = tog;
        cfg_out_reg = outr; cfg_fb_reg = fbr; cfg_clr_en = clre;
        model_eval();
        run_cycle('0, 1'b0, 1'b1, "R11");
    endtask

    task automatic run_random(input int n, input bit clk_toggle, input string tag);
        for (int c = 0; c < n; c++) begin
            logic [N-1:0] v = N'($urandom);
            bit lb = clk_toggle ? bit'(c % 2) : v[N-1];
            run_cycle(v, lb, 1'b0, tag);
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // PT0 = in0 & ~in1, PT1 = in2 & in3, PT2 = ~in4, PT7 empty and disabled
        cfg_and_mask[0*MW + 0] = 1; cfg_and_mask[0*MW + 3] = 1;
        cfg_and_mask[1*MW + 4] = 1; cfg_and_mask[1*MW + 6] = 1;
        cfg_and_mask[2*MW + 9] = 1;
        cfg_pt_en = 8'b0000_0111;
        cfg_aux_mask[2*(N-1)] = 1;            // auxiliary term = in7
        cfg_clr_mask[10] = 1; cfg_clr_mask[12] = 1; // clear term = in5 & in6
        model_eval();

        // Reset state with registered outputs
        set_mode(0, 0, 0, 0, 1, 1, 0);
        // R1 R4 R9 R10: sync D rising, clear disabled (R8 no effect)
        set_mode(0, 0, 0, 0, 1, 0, 0);
        run_random(24, 0, "R1/R4/R8/R9/R10");
        // R3 with swapped output selection
        set_mode(1, 0, 0, 0, 0, 1, 0);
        run_random(20, 0, "R3/R9/R10");
        // R7 toggle under global clock
        set_mode(0, 0, 0, 1, 1, 1, 0);
        run_random(20, 0, "R7");
        // R6 falling edge of the global clock
        set_mode(0, 0, 1, 0, 1, 0, 0);
        run_random(20, 0, "R6");
        // R5 local term clock, D mode
        set_mode(0, 1, 0, 0, 1, 0, 0);
        run_random(24, 1, "R5");
        // R5 R6 R7 local clock, falling edge, toggle, inverted
        set_mode(1, 1, 1, 1, 1, 1, 0);
        run_random(24, 1, "R5/R6/R7");
        // R8 clear term enabled, sync and async
        set_mode(0, 0, 0, 1, 1, 1, 1);
        run_random(24, 0, "R8");
        set_mode(0, 1, 0, 0, 1, 0, 1);
        run_random(24, 1, "R8");
        // R2 enabling an empty-mask term forces the sum to 1
        cfg_pt_en[NP-1] = 1'b1;
        set_mode(0, 0, 0, 0, 0, 1, 0);
        run_random(12, 0, "R2");
        cfg_pt_en = 8'b0000_0000;
        set_mode(1, 0, 0, 0, 0, 0, 0);
        run_random(8, 0, "R2");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule